// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a 39-bit virtual address to a physical address once a translation cache has missed. A request carries the virtual address and the root table page number taken from the translation control register. The walker then fetches one 64-bit page table entry per level from physical memory. It starts at the top index field and works down. Table addresses are physical and are never translated again.

Each fetched entry is decoded for its valid and leaf flags. A valid non-leaf entry supplies the page number of the next table. A valid leaf entry ends the walk successfully, and its page number is joined to the 12-bit page offset. An invalid entry ends the walk with a fault. So does a non-leaf entry at the lowest level. The outcome appears in a single-cycle done pulse. The walker is busy from acceptance through that pulse, and any request offered while it is busy is dropped.

Top module: `pt_walk3`

## Requirements
- R1: While reset is asserted, and in the first cycle after release, `walk_busy`, `walk_done` and `mem_req_valid` are low. An asserted reset abandons a walk in progress.
- R2: A request is taken only while `walk_busy` is low. `walk_busy` is high from the cycle after acceptance through the done cycle, and falls only after `walk_done`. A request offered while busy is ignored and starts no later memory read.
- R3: The entry address for a level is table_page * 4096 + index * 8. The index fields are vaddr[38:30] for the top level, vaddr[29:21] for the middle level and vaddr[20:12] for the bottom level. The top-level table page is `root_ppn`. Each lower table page is the page number of the entry fetched just before it.
- R4: Levels are read top, middle, bottom, with one read per level visited. A read is raised in the cycle after acceptance or after a descending response. It keeps the same address while `mem_req_ready` is low.
- R5: Entry layout: bit 0 valid, bit 1 readable, bit 2 writable, bit 3 executable, bits 53:10 page number. An entry is a leaf when the readable or executable bit is set.
- R6: A valid leaf at any level ends the walk with `walk_fault` low. `walk_paddr` is {leaf page number, vaddr[11:0]}.
- R7: An entry whose valid bit is clear ends the walk with a fault, whatever its other bits are. No further read is made.
- R8: A valid non-leaf entry at the bottom level ends the walk with a fault.
- R9: `walk_done` is high for exactly one cycle, the cycle after the response that ends the walk. `walk_paddr` is zero when `walk_fault` is high.
- R10: A valid entry with only the writable bit set among the permission bits is not a leaf. The walk descends through it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_req_valid | input | 1 | Translation request strobe |
| walk_req_vaddr | input | 39 | Virtual address to translate |
| root_ppn | input | 44 | Root table page number from the translation control register |
| walk_busy | output | 1 | Walk in progress; requests are ignored |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 56 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_pte | input | 64 | Returned page table entry |
| walk_done | output | 1 | One-cycle result strobe |
| walk_fault | output | 1 | Walk ended in a page fault |
| walk_paddr | output | 56 | Translated physical address (zero on fault) |

## Verification
Some properties hold on every cycle, and assertions check them. The read address stays fixed while memory stalls. Entry addresses are 8-byte aligned. No read is issued while the walker is idle. The done strobe never lasts two cycles. Busy drops only after done. A fault always returns a zero address. Other behaviour needs known inputs, so only the bench scenarios can show it. This covers the exact address arithmetic at each level, the top-to-bottom order of reads, and the outcome of each kind of entry: a leaf at each level, a clear valid bit, a bottom-level pointer and a writable-only pointer. It also covers the dropping of a request made during a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PTE_W       = 64;
  localparam int PTE_PPN_LSB = 10;
  localparam int PTE_SZ_LG   = 3;
  localparam int FLAG_V      = 0;
  localparam int FLAG_R      = 1;
  localparam int FLAG_W      = 2;
  localparam int FLAG_X      = 3;
  localparam int FLAG_TOP    = 3;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_REQ  = 2'd1,
    WK_WAIT = 2'd2,
    WK_DONE = 2'd3
  } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int PPN_W  = 44,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 3,
  parameter int OFF_W  = 12,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int VA_W  = LEVELS * IDX_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic [PPN_W-1:0] base_ppn,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  pte_addr
);
  logic [IDX_W-1:0] idx_tbl [LEVELS];
  logic [IDX_W-1:0] idx_sel;
  logic [OFF_W-1:0] unused_off;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_tbl[g] = vaddr[OFF_W + g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx_sel = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (level == LVL_W'(i)) idx_sel = idx_tbl[i];
    end
  end

  assign unused_off = vaddr[OFF_W-1:0];
  assign pte_addr   = {base_ppn, {OFF_W{1'b0}}} + (PA_W'(idx_sel) << PTE_SZ_LG);
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
#(
  parameter int PPN_W = 44
) (
  input  logic [PTE_W-1:0] pte,
  output logic             pte_valid,
  output logic             pte_leaf,
  output logic [PPN_W-1:0] pte_ppn
);
  logic unused_pte;

  assign pte_valid  = pte[FLAG_V];
  assign pte_leaf   = pte[FLAG_R] | pte[FLAG_X];
  assign pte_ppn    = pte[PTE_PPN_LSB +: PPN_W];
  assign unused_pte = ^{pte[PTE_W-1:PTE_PPN_LSB+PPN_W],
                        pte[PTE_PPN_LSB-1:FLAG_TOP+1], pte[FLAG_W]};
endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import ptw_pkg::*;
#(
  parameter int PPN_W  = 44,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 3,
  parameter int OFF_W  = 12,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int VA_W  = LEVELS * IDX_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic             pte_valid,
  input  logic             pte_leaf,
  input  logic [PPN_W-1:0] pte_ppn,
  output logic             busy,
  output logic             mem_req_valid,
  output logic [LVL_W-1:0] walk_level,
  output logic [PPN_W-1:0] walk_base,
  output logic [VA_W-1:0]  walk_vaddr,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  paddr
);
  walk_state_e      state_q, state_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic [PPN_W-1:0] base_q,  base_d;
  logic [VA_W-1:0]  va_q,    va_d;
  logic             fault_q, fault_d;
  logic [PA_W-1:0]  pa_q,    pa_d;
  logic             accept_en, rsp_en, data_en;

  assign accept_en = (state_q == WK_IDLE) && req_valid;
  assign rsp_en    = (state_q == WK_WAIT) && mem_rsp_valid;
  assign data_en   = accept_en || rsp_en;

  always_comb begin
    state_d = state_q;
    level_d = level_q;
    base_d  = base_q;
    va_d    = va_q;
    fault_d = fault_q;
    pa_d    = pa_q;
    unique case (state_q)
      WK_IDLE: begin
        if (req_valid) begin
          va_d    = req_vaddr;
          base_d  = root_ppn;
          level_d = LVL_W'(LEVELS - 1);
          state_d = WK_REQ;
        end
      end
      WK_REQ: begin
        if (mem_req_ready) state_d = WK_WAIT;
      end
      WK_WAIT: begin
        if (mem_rsp_valid) begin
          if (!pte_valid) begin
            fault_d = 1'b1;
            pa_d    = '0;
            state_d = WK_DONE;
          end else if (pte_leaf) begin
            fault_d = 1'b0;
            pa_d    = {pte_ppn, va_q[OFF_W-1:0]};
            state_d = WK_DONE;
          end else if (level_q == '0) begin
            fault_d = 1'b1;
            pa_d    = '0;
            state_d = WK_DONE;
          end else begin
            base_d  = pte_ppn;
            level_d = level_q - LVL_W'(1);
            state_d = WK_REQ;
          end
        end
      end
      WK_DONE: state_d = WK_IDLE;
      default: state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      base_q  <= '0;
      va_q    <= '0;
      fault_q <= 1'b0;
      pa_q    <= '0;
    end else if (data_en) begin
      level_q <= level_d;
      base_q  <= base_d;
      va_q    <= va_d;
      fault_q <= fault_d;
      pa_q    <= pa_d;
    end
  end

  assign busy          = (state_q != WK_IDLE);
  assign mem_req_valid = (state_q == WK_REQ);
  assign done          = (state_q == WK_DONE);
  assign walk_level    = level_q;
  assign walk_base     = base_q;
  assign walk_vaddr    = va_q;
  assign fault         = fault_q;
  assign paddr         = pa_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  // R9
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (paddr == '0));
endmodule

// File: rtl/pt_walk3.sv
module pt_walk3
  import ptw_pkg::*;
#(
  parameter int PPN_W  = 44,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 3,
  parameter int OFF_W  = 12,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int VA_W  = LEVELS * IDX_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             walk_req_valid,
  input  logic [VA_W-1:0]  walk_req_vaddr,
  input  logic [PPN_W-1:0] root_ppn,
  output logic             walk_busy,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_pte,
  output logic             walk_done,
  output logic             walk_fault,
  output logic [PA_W-1:0]  walk_paddr
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             dec_valid, dec_leaf;
  logic [PPN_W-1:0] dec_ppn;
  logic [LVL_W-1:0] cur_level;
  logic [PPN_W-1:0] cur_base;
  logic [VA_W-1:0]  cur_vaddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ptw_pte_decode #(.PPN_W(PPN_W)) i_decode (
    .pte       (mem_rsp_pte),
    .pte_valid (dec_valid),
    .pte_leaf  (dec_leaf),
    .pte_ppn   (dec_ppn)
  );

  ptw_walk_ctrl #(
    .PPN_W(PPN_W), .IDX_W(IDX_W), .LEVELS(LEVELS), .OFF_W(OFF_W)
  ) i_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .req_valid     (walk_req_valid),
    .req_vaddr     (walk_req_vaddr),
    .root_ppn      (root_ppn),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .pte_valid     (dec_valid),
    .pte_leaf      (dec_leaf),
    .pte_ppn       (dec_ppn),
    .busy          (walk_busy),
    .mem_req_valid (mem_req_valid),
    .walk_level    (cur_level),
    .walk_base     (cur_base),
    .walk_vaddr    (cur_vaddr),
    .done          (walk_done),
    .fault         (walk_fault),
    .paddr         (walk_paddr)
  );

  ptw_addr_gen #(
    .PPN_W(PPN_W), .IDX_W(IDX_W), .LEVELS(LEVELS), .OFF_W(OFF_W)
  ) i_addr (
    .base_ppn (cur_base),
    .vaddr    (cur_vaddr),
    .level    (cur_level),
    .pte_addr (mem_req_addr)
  );

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R3
  pte_align_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req_valid |-> (mem_req_addr[PTE_SZ_LG-1:0] == '0));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !walk_busy |-> (!mem_req_valid && !walk_done));
endmodule

// File: tb/test_pt_walk3.sv
module test_pt_walk3;
  typedef struct packed {
    logic [38:0] vaddr;
    logic [43:0] root;
    logic [63:0] pte2;
    logic [63:0] pte1;
    logic [63:0] pte0;
    logic [1:0]  nrd;
    logic        flt;
    logic [43:0] lppn;
    logic [1:0]  kind;
  } vec_t;

  function automatic logic [63:0] mkpte(input logic [43:0] p, input logic [3:0] f);
    return {10'b0, p, 6'b0, f};
  endfunction

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{39'h0A_BCDE_F123, 44'h100, mkpte(44'h200, 4'h1), mkpte(44'h300, 4'h1),
      mkpte(44'h4567, 4'h3), 2'd3, 1'b0, 44'h4567, 2'd0},
    '{39'h7F_FFFF_FFFF, 44'hFFF_FFFF_FF00, mkpte(44'h1000, 4'h1), mkpte(44'h2000, 4'h1),
      mkpte(44'hFFF_FFFF_FFFF, 4'hB), 2'd3, 1'b0, 44'hFFF_FFFF_FFFF, 2'd0},
    '{39'h00_0000_0000, 44'h0, mkpte(44'hABC00, 4'h9), 64'h0, 64'h0,
      2'd1, 1'b0, 44'hABC00, 2'd0},
    '{39'h40_2010_0FFF, 44'h55, mkpte(44'h66, 4'h1), mkpte(44'h7777, 4'h3), 64'h0,
      2'd2, 1'b0, 44'h7777, 2'd0},
    '{39'h12_3456_7000, 44'h800, mkpte(44'h123, 4'hE), 64'h0, 64'h0,
      2'd1, 1'b1, 44'h0, 2'd1},
    '{39'h31_0F0F_0ABC, 44'h801, mkpte(44'h44, 4'h1), mkpte(44'h9, 4'h0), 64'h0,
      2'd2, 1'b1, 44'h0, 2'd1},
    '{39'h55_5555_5555, 44'h802, mkpte(44'h45, 4'h1), mkpte(44'h46, 4'h1),
      mkpte(44'h5, 4'h1), 2'd3, 1'b1, 44'h0, 2'd2},
    '{39'h2A_AAAA_A00F, 44'h803, mkpte(44'h321, 4'h5), mkpte(44'h654, 4'h1),
      mkpte(44'h987, 4'h3), 2'd3, 1'b0, 44'h987, 2'd3}
  };

  logic        clk, rst_n;
  logic        walk_req_valid;
  logic [38:0] walk_req_vaddr;
  logic [43:0] root_ppn;
  logic        walk_busy, mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [55:0] mem_req_addr, walk_paddr;
  logic [63:0] mem_rsp_pte;
  logic        walk_done, walk_fault;

  int  checks = 0;
  int  errors = 0;
  bit  ended  = 0;

  pt_walk3 i_pt_walk3 (
    .clk(clk), .rst_n(rst_n),
    .walk_req_valid(walk_req_valid), .walk_req_vaddr(walk_req_vaddr),
    .root_ppn(root_ppn), .walk_busy(walk_busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_pte(mem_rsp_pte), .walk_done(walk_done),
    .walk_fault(walk_fault), .walk_paddr(walk_paddr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [63:0] pick(input vec_t v, input int k);
    case (k)
      0: return v.pte2;
      1: return v.pte1;
      2: return v.pte0;
      default: return 64'h0;
    endcase
  endfunction

  function automatic string kind_req(input logic [1:0] k);
    case (k)
      2'd1: return "R7";
      2'd2: return "R8";
      2'd3: return "R10";
      default: return "R6";
    endcase
  endfunction

  task automatic run_vec(input int i, input bit inject, input int stall);
    vec_t        v;
    logic [43:0] base;
    logic [55:0] ea;
    logic [55:0] epa;
    logic [63:0] pte;
    int          reads, cyc;
    bit          fin;
    v = VECS[i];
    @(negedge clk);
    walk_req_valid = 1'b1; walk_req_vaddr = v.vaddr; root_ppn = v.root;
    @(negedge clk);
    walk_req_valid = 1'b0;
    chk(walk_busy == 1'b1, "R2", 64'(walk_busy), 64'h1);
    base = v.root; reads = 0; cyc = 0; fin = 0;
    while (!fin && cyc < 60) begin
      if (walk_done) begin
        fin = 1;
      end else if (mem_req_valid && reads < 3) begin
        ea = {base, 12'h0} + (56'(v.vaddr[12 + 9*(2-reads) +: 9]) << 3);
        chk(mem_req_addr == ea, "R3", 64'(mem_req_addr), 64'(ea));
        if (stall > 0) begin
          mem_req_ready = 1'b0;
          repeat (stall) begin
            @(negedge clk);
            chk(mem_req_valid && mem_req_addr == ea, "R4", 64'(mem_req_addr), 64'(ea));
          end
          mem_req_ready = 1'b1;
        end
        @(negedge clk);
        pte = pick(v, reads);
        mem_rsp_valid = 1'b1; mem_rsp_pte = pte;
        if (inject && reads == 0) begin
          walk_req_valid = 1'b1; walk_req_vaddr = ~v.vaddr;
        end
        @(negedge clk);
        mem_rsp_valid = 1'b0; walk_req_valid = 1'b0;
        base = pte[53:10];
        reads++;
      end else begin
        @(negedge clk);
      end
      cyc++;
    end
    chk(fin, "R9", 64'(fin), 64'h1);
    epa = v.flt ? 56'h0 : {v.lppn, v.vaddr[11:0]};
    chk(reads == int'(v.nrd), "R4", 64'(reads), 64'(v.nrd));
    chk(walk_fault == v.flt, kind_req(v.kind), 64'(walk_fault), 64'(v.flt));
    chk(walk_paddr == epa, kind_req(v.kind), 64'(walk_paddr), 64'(epa));
    @(negedge clk);
    chk(!walk_done, "R9", 64'(walk_done), 64'h0);
    chk(!walk_busy, "R2", 64'(walk_busy), 64'h0);
    if (inject) begin
      repeat (3) begin
        @(negedge clk);
        chk(!mem_req_valid && !walk_busy, "R2", 64'(mem_req_valid), 64'h0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; walk_req_valid = 1'b0; walk_req_vaddr = '0; root_ppn = '0;
    mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_pte = '0;
    repeat (3) @(negedge clk);
    chk(!walk_busy && !walk_done && !mem_req_valid, "R1", 64'(walk_busy), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!walk_busy && !walk_done && !mem_req_valid, "R1", 64'(mem_req_valid), 64'h0);
    repeat (3) @(negedge clk);

    // main table: leaves at each level, faults (R5..R8), write-only pointer (R10)
    for (int i = 0; i < NVEC; i++) run_vec(i, 1'b0, 0);

    // R2: request while busy is dropped
    run_vec(0, 1'b1, 0);
    // R4: stalled memory keeps the read address
    run_vec(7, 1'b0, 3);
    run_vec(3, 1'b1, 2);

    // R1: reset in the middle of a walk
    @(negedge clk);
    walk_req_valid = 1'b1; walk_req_vaddr = VECS[0].vaddr; root_ppn = VECS[0].root;
    @(negedge clk);
    walk_req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!walk_busy && !mem_req_valid && !walk_done, "R1", 64'(walk_busy), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!walk_busy && !mem_req_valid, "R1", 64'(mem_req_valid), 64'h0);
    run_vec(2, 1'b0, 0);

    finish_run();
  end
endmodule